// File: doc/BRIEF.md
# Serial Wire Debug Host Transaction Engine

This block is the host side of a serial wire debug link. It runs exactly one transaction each time it is started. It sends an 8-bit request header and checks the 3-bit acknowledge from the target. Depending on that acknowledge, it either moves 32 data bits with a parity bit in the requested direction or closes the transaction early. The pin interface is a clock output, a data output, an output enable for the data pad and a data input, so the pad buffer sits outside the block.

The bit rate comes from a divider value captured when a transaction is accepted. A parameter sets the number of turnaround cycles, so a slow pad can be given more time to change direction. Every transaction ends with one driven-low bit cell. After that the block idles with the clock high and the data line driven low. Results stay on the outputs from the completion pulse until the next completion. A read reports a parity mismatch separately from the acknowledge code.

Top module: `swd_host_engine`

## Requirements
- R1: After reset the block is idle: startReady=1, swclk=1, swdioOe=1, swdioOut=0, done=0, ackCode=0, rdData=0, parityErr=0.
- R2: A transaction accepted on startValid with startReady first drives the 8 header bits, bit 0 first, one bit per clock cell with swdioOe=1.
- R3: After the header, the line is released for TURN cells. Then 3 acknowledge bits are sampled, bit 0 first, and reported on ackCode. The encodings are OK=3'b001, WAIT=3'b010 and FAULT=3'b100.
- R4: On OK with reqWrite=0, 32 data bits are sampled bit 0 first into rdData. One parity bit follows, then TURN released cells. The whole transaction takes 8+TURN+3+33+TURN+1 cells.
- R5: parityErr is 1 exactly when an OK read's received parity bit differs from the XOR of the 32 received bits. It is 0 for every other transaction.
- R6: On OK with reqWrite=1, TURN released cells come first. Then the captured wrData is driven bit 0 first, followed by its XOR parity bit. The transaction takes 8+TURN+3+TURN+33+1 cells.
- R7: On WAIT or FAULT, TURN released cells follow and the transaction ends with no data phase, in 8+2*TURN+3+1 cells.
- R8: On any other acknowledge, the line stays released for 33+TURN further cells before driving resumes. rdData reports 0.
- R9: Each input bit is sampled at the end of the clock's low phase. swdioOe changes only while swclk is low, and the host never drives while the target drives.
- R10: Each clock phase lasts clkDiv+1 system cycles, using the clkDiv value captured at acceptance. A transaction of N cells therefore takes N*2*(clkDiv+1) cycles.
- R11: startReady is low for the whole transaction. done is a single-cycle pulse that coincides with updated results, and the results hold afterwards.
- R12: Every transaction ends with one driven-low cell. The block then returns to idle with swclk=1, swdioOe=1 and swdioOut=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startValid | input | 1 | Request to start a transaction |
| startReady | output | 1 | High while idle and able to accept |
| reqHeader | input | 8 | Request header, sent bit 0 first |
| reqWrite | input | 1 | 1 for a write data phase, 0 for a read |
| wrData | input | 32 | Write data, captured at acceptance |
| clkDiv | input | DIV_W | Phase length minus one, in system cycles |
| done | output | 1 | One-cycle completion pulse |
| ackCode | output | 3 | Acknowledge received |
| rdData | output | 32 | Read data, zero unless an OK read |
| parityErr | output | 1 | Read parity mismatch |
| swclk | output | 1 | Serial clock, idles high |
| swdioOut | output | 1 | Data value driven to the pad |
| swdioOe | output | 1 | Pad output enable |
| swdioIn | input | 1 | Data value seen at the pad |

## Verification
The assertions assume that swdioIn settles before the end of each low phase and that the target drives only during cells in which the host has released the line. The bench target model responds only in the acknowledge and read-data cells, computed from counted clock rises. It shows the inverted bit during each high phase, so a sample taken at the wrong moment produces wrong data. The header, the write data and the divider are changed right after acceptance, so the stimulus depends only on values captured in the accept cycle, as the properties on held results expect.

// File: rtl/swd_pkg.sv
package swd_pkg;
  localparam int HDR_BITS  = 8;
  localparam int ACK_BITS  = 3;
  localparam int DATA_BITS = 32;
  localparam int CNT_W     = $clog2(DATA_BITS + 1);

  localparam logic [ACK_BITS-1:0] ACK_OK    = 3'b001;
  localparam logic [ACK_BITS-1:0] ACK_WAIT  = 3'b010;
  localparam logic [ACK_BITS-1:0] ACK_FAULT = 3'b100;

  typedef enum logic [3:0] {
    ST_IDLE, ST_HDR, ST_TRN1, ST_ACK, ST_RDATA,
    ST_RPAR, ST_TRN2, ST_WDATA, ST_WPAR, ST_TAIL
  } stage_e;

  typedef enum logic [1:0] { DRV_ZERO, DRV_SHIFT, DRV_PAR } drv_e;

  typedef struct packed {
    logic loadReq;
    logic loadWr;
    logic shiftOut;
    logic takeAck;
    logic takeData;
    logic takePar;
    logic finish;
    logic readOk;
    logic oe;
    drv_e drvSel;
  } strobe_t;
endpackage

// File: rtl/swd_ctrl.sv
module swd_ctrl
  import swd_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int TURN  = 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                startValid,
  output logic                startReady,
  input  logic                reqWrite,
  input  logic [DIV_W-1:0]    clkDiv,
  input  logic [ACK_BITS-1:0] ackIn,
  output strobe_t             strb,
  output logic                swclk,
  output logic                done
);
  localparam logic [DIV_W-1:0] PH_ONE  = 1;
  localparam logic [CNT_W-1:0] BIT_ONE = 1;

  stage_e            stage, nextStage;
  logic [CNT_W-1:0]  bitCnt, stageLen;
  logic [DIV_W-1:0]  phaseCnt, divHold;
  logic              clkLow, isWrite, doneR;
  logic              tick, lowEnd, cellEnd, lastBit, ackOk, ackShort;

  assign tick     = (phaseCnt == divHold);
  assign lowEnd   = (stage != ST_IDLE) && clkLow && tick;
  assign cellEnd  = (stage != ST_IDLE) && !clkLow && tick;
  assign ackOk    = (ackIn == ACK_OK);
  assign ackShort = (ackIn == ACK_WAIT) || (ackIn == ACK_FAULT);

  always_comb begin
    case (stage)
      ST_HDR:             stageLen = CNT_W'(HDR_BITS);
      ST_TRN1, ST_TRN2:   stageLen = CNT_W'(TURN);
      ST_ACK:             stageLen = CNT_W'(ACK_BITS);
      ST_RDATA, ST_WDATA: stageLen = CNT_W'(DATA_BITS);
      default:            stageLen = BIT_ONE;
    endcase
  end
  assign lastBit = (bitCnt == stageLen - BIT_ONE);

  // Cell sequence; the data phase layout depends on the acknowledge.
  always_comb begin
    case (stage)
      ST_HDR:   nextStage = ST_TRN1;
      ST_TRN1:  nextStage = ST_ACK;
      ST_ACK:   nextStage = ackOk ? (isWrite ? ST_TRN2 : ST_RDATA)
                                  : (ackShort ? ST_TRN2 : ST_RDATA);
      ST_RDATA: nextStage = ST_RPAR;
      ST_RPAR:  nextStage = ST_TRN2;
      ST_TRN2:  nextStage = (ackOk && isWrite) ? ST_WDATA : ST_TAIL;
      ST_WDATA: nextStage = ST_WPAR;
      ST_WPAR:  nextStage = ST_TAIL;
      default:  nextStage = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage    <= ST_IDLE;
      bitCnt   <= '0;
      phaseCnt <= '0;
      divHold  <= '0;
      clkLow   <= 1'b0;
      isWrite  <= 1'b0;
      doneR    <= 1'b0;
    end else begin
      doneR <= 1'b0;
      if (stage == ST_IDLE) begin
        if (startValid) begin
          stage    <= ST_HDR;
          bitCnt   <= '0;
          phaseCnt <= '0;
          divHold  <= clkDiv;
          clkLow   <= 1'b1;
          isWrite  <= reqWrite;
        end
      end else if (tick) begin
        phaseCnt <= '0;
        if (clkLow) begin
          clkLow <= 1'b0;
        end else if (lastBit) begin
          stage  <= nextStage;
          bitCnt <= '0;
          if (nextStage == ST_IDLE) doneR <= 1'b1;
          else clkLow <= 1'b1;
        end else begin
          bitCnt <= bitCnt + BIT_ONE;
          clkLow <= 1'b1;
        end
      end else begin
        phaseCnt <= phaseCnt + PH_ONE;
      end
    end
  end

  always_comb begin
    strb          = '0;
    strb.loadReq  = (stage == ST_IDLE) && startValid;
    strb.loadWr   = cellEnd && lastBit && (stage == ST_TRN2) && ackOk && isWrite;
    strb.shiftOut = cellEnd && ((stage == ST_HDR) || (stage == ST_WDATA));
    strb.takeAck  = lowEnd && (stage == ST_ACK);
    strb.takeData = lowEnd && (stage == ST_RDATA);
    strb.takePar  = lowEnd && (stage == ST_RPAR);
    strb.finish   = cellEnd && (stage == ST_TAIL);
    strb.readOk   = ackOk && !isWrite;
    strb.oe       = (stage == ST_IDLE) || (stage == ST_HDR) || (stage == ST_WDATA) ||
                    (stage == ST_WPAR) || (stage == ST_TAIL);
    case (stage)
      ST_HDR, ST_WDATA: strb.drvSel = DRV_SHIFT;
      ST_WPAR:          strb.drvSel = DRV_PAR;
      default:          strb.drvSel = DRV_ZERO;
    endcase
  end

  assign startReady = (stage == ST_IDLE);
  assign swclk      = !clkLow;
  assign done       = doneR;

  // R9: pad direction only switches inside a low clock phase
  a_r9_oe_in_low: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(strb.oe) |-> !swclk);
  // R11: completion is a single pulse
  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  // R11: completion leaves the block ready
  a_r11_done_ready: assert property (@(posedge clk) disable iff (!rstN)
    done |-> startReady);
  // R1 / R12: idle means clock high and line driven
  a_r12_idle_pins: assert property (@(posedge clk) disable iff (!rstN)
    startReady |-> (swclk && strb.oe));
endmodule

// File: rtl/swd_datapath.sv
module swd_datapath
  import swd_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              strb,
  input  logic [HDR_BITS-1:0]  reqHeader,
  input  logic [DATA_BITS-1:0] wrData,
  input  logic                 swdioIn,
  output logic                 swdioOut,
  output logic                 swdioOe,
  output logic [ACK_BITS-1:0]  ackSh,
  output logic [ACK_BITS-1:0]  ackCode,
  output logic [DATA_BITS-1:0] rdData,
  output logic                 parityErr
);
  logic [DATA_BITS-1:0] shReg, wrHold;
  logic                 wrPar, parBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg     <= '0;
      wrHold    <= '0;
      wrPar     <= 1'b0;
      parBit    <= 1'b0;
      ackSh     <= '0;
      ackCode   <= '0;
      rdData    <= '0;
      parityErr <= 1'b0;
    end else begin
      if (strb.loadReq) begin
        shReg  <= {{(DATA_BITS-HDR_BITS){1'b0}}, reqHeader};
        wrHold <= wrData;
        wrPar  <= ^wrData;
        ackSh  <= '0;
        parBit <= 1'b0;
      end else if (strb.loadWr) begin
        shReg <= wrHold;
      end else if (strb.shiftOut) begin
        shReg <= shReg >> 1;
      end else if (strb.takeData) begin
        shReg <= {swdioIn, shReg[DATA_BITS-1:1]};
      end
      if (strb.takeAck) ackSh  <= {swdioIn, ackSh[ACK_BITS-1:1]};
      if (strb.takePar) parBit <= swdioIn;
      if (strb.finish) begin
        ackCode   <= ackSh;
        rdData    <= strb.readOk ? shReg : '0;
        parityErr <= strb.readOk && (parBit != ^shReg);
      end
    end
  end

  always_comb begin
    case (strb.drvSel)
      DRV_SHIFT: swdioOut = shReg[0];
      DRV_PAR:   swdioOut = wrPar;
      default:   swdioOut = 1'b0;
    endcase
  end
  assign swdioOe = strb.oe;

  // R5: a parity error is only reported for an OK acknowledge
  a_r5_perr_needs_ok: assert property (@(posedge clk) disable iff (!rstN)
    parityErr |-> (ackCode == ACK_OK));
  // R8: read data stays zero unless the acknowledge was OK
  a_r8_rd_zero: assert property (@(posedge clk) disable iff (!rstN)
    (rdData != '0) |-> (ackCode == ACK_OK));
endmodule

// File: rtl/swd_host_engine.sv
module swd_host_engine
  import swd_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int TURN  = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startValid,
  output logic             startReady,
  input  logic [7:0]       reqHeader,
  input  logic             reqWrite,
  input  logic [31:0]      wrData,
  input  logic [DIV_W-1:0] clkDiv,
  output logic             done,
  output logic [2:0]       ackCode,
  output logic [31:0]      rdData,
  output logic             parityErr,
  output logic             swclk,
  output logic             swdioOut,
  output logic             swdioOe,
  input  logic             swdioIn
);
  strobe_t             strb;
  logic [ACK_BITS-1:0] ackSh;

  swd_ctrl #(.DIV_W(DIV_W), .TURN(TURN)) u_ctrl (
    .clk(clk), .rstN(rstN), .startValid(startValid), .startReady(startReady),
    .reqWrite(reqWrite), .clkDiv(clkDiv), .ackIn(ackSh), .strb(strb),
    .swclk(swclk), .done(done)
  );

  swd_datapath u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .reqHeader(reqHeader), .wrData(wrData),
    .swdioIn(swdioIn), .swdioOut(swdioOut), .swdioOe(swdioOe), .ackSh(ackSh),
    .ackCode(ackCode), .rdData(rdData), .parityErr(parityErr)
  );
endmodule

// File: tb/test_swd_host_engine.sv
module test_swd_host_engine;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 9;

  typedef struct packed {
    logic [7:0]  hdr;
    logic        wr;
    logic [31:0] wdata;
    logic [2:0]  ack;
    logic [31:0] rdata;
    logic        badPar;
    logic [7:0]  div;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{8'hA5, 1'b0, 32'h0,        3'b001, 32'h12345678, 1'b0, 8'd0},
    '{8'h8D, 1'b0, 32'h0,        3'b001, 32'hFFFF0001, 1'b1, 8'd1},
    '{8'h81, 1'b0, 32'h0,        3'b001, 32'h00000000, 1'b1, 8'd0},
    '{8'hA9, 1'b1, 32'hDEADBEEF, 3'b001, 32'h0,        1'b0, 8'd0},
    '{8'hB1, 1'b1, 32'h00000001, 3'b001, 32'h0,        1'b0, 8'd2},
    '{8'h9F, 1'b0, 32'h0,        3'b010, 32'hCAFE0000, 1'b0, 8'd0},
    '{8'hC3, 1'b1, 32'h55AA55AA, 3'b100, 32'h0,        1'b0, 8'd1},
    '{8'hE7, 1'b0, 32'h0,        3'b111, 32'h89ABCDEF, 1'b0, 8'd0},
    '{8'h0F, 1'b1, 32'h13572468, 3'b000, 32'h0,        1'b0, 8'd0}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startValid = 1'b0;
  logic        startReady;
  logic [7:0]  reqHeader = '0;
  logic        reqWrite = 1'b0;
  logic [31:0] wrData = '0;
  logic [7:0]  clkDiv = '0;
  logic        done;
  logic [2:0]  ackCode;
  logic [31:0] rdData;
  logic        parityErr;
  logic        swclk, swdioOut, swdioOe, swdioIn;

  int checks = 0;
  int errors = 0;

  // target model state
  logic [2:0]  tgtAck = '0;
  logic [31:0] tgtRd = '0;
  logic        tgtBad = 1'b0;
  logic        tgtOkRead = 1'b0;
  logic        tgtDrv, tgtVal;
  int          riseCnt = 100;
  int          relCnt = 0;
  int          contention = 0;
  int          oeBad = 0;
  logic [7:0]  hdrSeen = '0;
  logic [31:0] wrSeen = '0;
  logic        wrParSeen = 1'b0;
  logic        prevClk = 1'b1;
  logic        prevOe = 1'b1;

  always #(CLK_PERIOD/2) clk = ~clk;

  swd_host_engine i_swd_host_engine (
    .clk(clk), .rstN(rstN), .startValid(startValid), .startReady(startReady),
    .reqHeader(reqHeader), .reqWrite(reqWrite), .wrData(wrData), .clkDiv(clkDiv),
    .done(done), .ackCode(ackCode), .rdData(rdData), .parityErr(parityErr),
    .swclk(swclk), .swdioOut(swdioOut), .swdioOe(swdioOe), .swdioIn(swdioIn)
  );

  always_comb begin
    tgtDrv = 1'b0;
    tgtVal = 1'b0;
    if (riseCnt >= 9 && riseCnt <= 11) begin
      tgtDrv = 1'b1; tgtVal = tgtAck[riseCnt-9];
    end else if (tgtOkRead && riseCnt >= 12 && riseCnt <= 43) begin
      tgtDrv = 1'b1; tgtVal = tgtRd[riseCnt-12];
    end else if (tgtOkRead && riseCnt == 44) begin
      tgtDrv = 1'b1; tgtVal = (^tgtRd) ^ tgtBad;
    end
  end
  // inverted value during the high phase exposes a late sample
  assign swdioIn = tgtDrv ? (swclk ? ~tgtVal : tgtVal) : (swdioOe ? swdioOut : 1'b1);

  always @(posedge clk) begin
    prevClk <= swclk;
    prevOe  <= swdioOe;
    if (swdioOe != prevOe && swclk) oeBad <= oeBad + 1;
    if (swdioOe && tgtDrv) contention <= contention + 1;
    if (startValid && startReady) begin
      riseCnt <= 0; relCnt <= 0; hdrSeen <= '0; wrSeen <= '0; wrParSeen <= 1'b0;
    end else if (swclk && !prevClk) begin
      if (!swdioOe) relCnt <= relCnt + 1;
      if (riseCnt < 8) hdrSeen[riseCnt] <= swdioOut;
      if (riseCnt >= 13 && riseCnt <= 44) wrSeen[riseCnt-13] <= swdioOut;
      if (riseCnt == 45) wrParSeen <= swdioOut;
      riseCnt <= riseCnt + 1;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic runVec(input vec_t v);
    int cyc;
    int cells;
    int rel;
    logic okRead, okWrite, shortAck;
    okRead   = (v.ack == 3'b001) && !v.wr;
    okWrite  = (v.ack == 3'b001) && v.wr;
    shortAck = (v.ack == 3'b010) || (v.ack == 3'b100);
    tgtAck = v.ack; tgtRd = v.rdata; tgtBad = v.badPar; tgtOkRead = okRead;
    @(negedge clk);
    reqHeader = v.hdr; reqWrite = v.wr; wrData = v.wdata; clkDiv = v.div;
    startValid = 1'b1;
    @(negedge clk);
    startValid = 1'b0;
    reqHeader = ~v.hdr; wrData = ~v.wdata; clkDiv = ~v.div;  // R10: captured at accept
    cyc = 0;
    while (!done && cyc < 20000) begin
      @(negedge clk);
      cyc++;
      if (cyc == 3) check("R11 busy startReady", 32'(startReady), 32'd0);
    end
    if (cyc >= 20000) check("R11 watchdog", 32'd0, 32'd1);
    cells = shortAck ? 14 : 47;
    rel   = (okWrite || shortAck) ? 5 : 38;
    check("R10 transaction cycles", 32'(cyc), 32'(cells * 2 * (int'(v.div) + 1)));
    check("R2 header bits", 32'(hdrSeen), 32'(v.hdr));
    check("R3 ackCode", 32'(ackCode), 32'(v.ack));
    if (okRead)        check("R4 released cells read", 32'(relCnt), 32'(rel));
    else if (shortAck) check("R7 released cells short", 32'(relCnt), 32'(rel));
    else if (okWrite)  check("R6 released cells write", 32'(relCnt), 32'(rel));
    else               check("R8 released cells invalid", 32'(relCnt), 32'(rel));
    if (okRead) check("R4 R9 rdData", rdData, v.rdata);
    else        check("R8 rdData zero", rdData, 32'd0);
    check("R5 parityErr", 32'(parityErr), 32'(okRead && v.badPar));
    if (okWrite) begin
      check("R6 write data", wrSeen, v.wdata);
      check("R6 write parity", 32'(wrParSeen), 32'(^v.wdata));
    end
    check("R9 no contention", 32'(contention), 32'd0);
    check("R9 oe change in low phase", 32'(oeBad), 32'd0);
    @(negedge clk);
    check("R11 done single cycle", 32'(done), 32'd0);
    check("R11 ackCode held", 32'(ackCode), 32'(v.ack));
    check("R12 idle pins", {28'd0, startReady, swclk, swdioOe, swdioOut}, 32'hE);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    check("watchdog expired", 32'd0, 32'd1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset pins", {28'd0, startReady, swclk, swdioOe, swdioOut}, 32'hE);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 idle pins", {28'd0, startReady, swclk, swdioOe, swdioOut}, 32'hE);
    check("R1 results zero", {27'd0, done, ackCode, parityErr}, 32'd0);
    check("R1 rdData zero", rdData, 32'd0);
    for (int i = 0; i < NVEC; i++) runVec(VECS[i]);
    // corner: back-to-back start right after completion, slowest divider used
    runVec('{8'hFF, 1'b1, 32'hFFFFFFFF, 3'b001, 32'h0, 1'b0, 8'd3});
    runVec('{8'h00, 1'b0, 32'h0, 3'b001, 32'h80000000, 1'b0, 8'd0});
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule